// File: doc/BRIEF.md
# Debug Cross-Trigger Routing Matrix

This block carries debug events between on-chip agents. Each trigger input can be fanned onto any of a small set of broadcast channels. Each trigger output watches any subset of those channels. When the unit is enabled and a watched channel becomes active, the output latches high and stays high until software retires it. That makes an output suitable as a level interrupt. Software may also drive channels directly: it can hold a channel with a set/clear pair, or fire it for a single clock.

All configuration travels over a simple 32-bit register bus with a byte address. A write takes effect at the clock edge where `bus_wr` is sampled high. A read is sampled at the edge where `bus_rd` is high, and its data is returned in the following cycle, qualified by `bus_rvalid`.

A two-state key machine guards the map. The states are CLOSED (the reset state) and OPEN. The transition CLOSED→OPEN (`unlock`) happens when the key value is written to the key register. The transition OPEN→CLOSED (`relock`) happens when any other value is written there. Writing the key again in OPEN, or a bad value in CLOSED, leaves the state unchanged. While CLOSED, only the key register accepts writes.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset the unit is CLOSED (offset 0xFB4 bit 0 reads 1), the control register and all masks read 0, and `trig_out` is 0.
- R2: Writing 0xC5ACCE55 to offset 0xFB0 moves to OPEN (0xFB4 bit 0 reads 0). Writing any other value there moves to CLOSED.
- R3: While CLOSED, writes to every offset except 0xFB0 are ignored. The control and mask registers keep their values.
- R4: Bit 0 of the control register at 0x000 is the global enable. While it is 0, no trigger output becomes set.
- R5: Trigger input n has a channel mask at 0x020+4n. When bit c is set and input n is high, channel c is active. The channel-from-inputs status at 0x138 shows this with bit c = channel c.
- R6: Trigger output n has a channel mask at 0x0A0+4n. When the unit is enabled and a masked channel is active, output n is set at the next clock edge.
- R7: A set output stays high after its channels go idle. It clears at the edge where 1 is written to bit n of the acknowledge register at 0x010.
- R8: If output n's trigger condition is still true in the cycle of an acknowledge, the output stays set.
- R9: Writing 1 to bit c at 0x014 holds channel c active. Writing 1 to bit c at 0x018 releases it. The channel-out status at 0x13C shows all active channels.
- R10: A write to 0x01C makes each channel whose bit is 1 active for exactly the one cycle after the write edge.
- R11: Offset 0x130 reads the trigger input pins, and 0x134 reads the latched trigger outputs.
- R12: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High the cycle after a sampled read |
| trig_in | input | 8 | Trigger inputs |
| trig_out | output | 8 | Latched trigger outputs |

## Verification
The routing path is first tried with a single input mapped through one channel to one output. This distinguishes the per-input and per-output mask offsets from each other. The same output is then driven by a held software set and by a single-cycle pulse. These show whether channel activity is sourced from the pins, from the held bits, or from the one-shot register, and the read of 0x13C on two consecutive cycles separates a one-clock pulse from a stuck one. Acknowledges are issued both with the trigger still high and with it low, which separates the precedence rule from the plain clear. Writes made while CLOSED, and writes to unmapped offsets, are followed by readback of the registers they could have altered.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

    typedef enum logic [0:0] {
        LK_CLOSED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_t;

    localparam logic [31:0] KEY_VALUE = 32'hC5AC_CE55;

    // word indices (byte offset / 4)
    localparam logic [9:0] W_CTRL    = 10'h000;
    localparam logic [9:0] W_ACK     = 10'h004;
    localparam logic [9:0] W_SWSET   = 10'h005;
    localparam logic [9:0] W_SWCLR   = 10'h006;
    localparam logic [9:0] W_PULSE   = 10'h007;
    localparam logic [9:0] W_INMASK  = 10'h008;
    localparam logic [9:0] W_OUTMASK = 10'h028;
    localparam logic [9:0] W_ST_TIN  = 10'h04C;
    localparam logic [9:0] W_ST_TOUT = 10'h04D;
    localparam logic [9:0] W_ST_CHI  = 10'h04E;
    localparam logic [9:0] W_ST_CHO  = 10'h04F;
    localparam logic [9:0] W_KEY     = 10'h3EC;
    localparam logic [9:0] W_LKSTAT  = 10'h3ED;

endpackage

// File: rtl/xtrig_lock_fsm.sv
module xtrig_lock_fsm
    import xtrig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic        locked
);
    lock_state_t state_q, state_d;
    logic key_wr;

    assign key_wr = wr_en && (addr[11:2] == W_KEY);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLOSED: if (key_wr && wdata == KEY_VALUE) state_d = LK_OPEN;   // unlock
            LK_OPEN:   if (key_wr && wdata != KEY_VALUE) state_d = LK_CLOSED; // relock
            default:   state_d = LK_CLOSED;
        endcase
    end

    always_comb locked = (state_q == LK_CLOSED);

    logic unused_addr;
    assign unused_addr = ^addr[1:0];

    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata == KEY_VALUE) |=> !locked);
    p_badkey_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata != KEY_VALUE) |=> locked);
endmodule

// File: rtl/xtrig_regs.sv
module xtrig_regs
    import xtrig_pkg::*;
#(
    parameter int N_TIN  = 8,
    parameter int N_TOUT = 8,
    parameter int N_CH   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     locked,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [11:0]              addr,
    input  logic [31:0]              wdata,
    input  logic [N_TIN-1:0]         st_tin,
    input  logic [N_TOUT-1:0]        st_tout,
    input  logic [N_CH-1:0]          st_chi,
    input  logic [N_CH-1:0]          st_cho,
    output logic                     en,
    output logic [N_TIN*N_CH-1:0]    in_mask,
    output logic [N_TOUT*N_CH-1:0]   out_mask,
    output logic [N_CH-1:0]          sw_hold,
    output logic [N_CH-1:0]          sw_pulse,
    output logic [N_TOUT-1:0]        ack,
    output logic [31:0]              rdata,
    output logic                     rvalid
);
    logic [9:0]      widx;
    logic            wr_ok;
    logic            en_q;
    logic [N_CH-1:0] inm_q  [N_TIN];
    logic [N_CH-1:0] outm_q [N_TOUT];
    logic [N_CH-1:0] hold_q, pulse_q;
    logic [31:0]     rd_d, rdata_q;
    logic            rvalid_q;

    assign widx  = addr[11:2];
    assign wr_ok = wr_en && !locked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            hold_q  <= '0;
            pulse_q <= '0;
            for (int n = 0; n < N_TIN; n++)  inm_q[n]  <= '0;
            for (int n = 0; n < N_TOUT; n++) outm_q[n] <= '0;
        end else begin
            pulse_q <= (wr_ok && widx == W_PULSE) ? wdata[N_CH-1:0] : '0;
            if (wr_ok) begin
                if (widx == W_CTRL)  en_q   <= wdata[0];
                if (widx == W_SWSET) hold_q <= hold_q | wdata[N_CH-1:0];
                if (widx == W_SWCLR) hold_q <= hold_q & ~wdata[N_CH-1:0];
                for (int n = 0; n < N_TIN; n++)
                    if (widx == W_INMASK + 10'(n)) inm_q[n] <= wdata[N_CH-1:0];
                for (int n = 0; n < N_TOUT; n++)
                    if (widx == W_OUTMASK + 10'(n)) outm_q[n] <= wdata[N_CH-1:0];
            end
        end
    end

    assign ack = (wr_ok && widx == W_ACK) ? wdata[N_TOUT-1:0] : '0;

    always_comb begin
        rd_d = '0;
        unique case (widx)
            W_CTRL:    rd_d = {31'd0, en_q};
            W_SWSET:   rd_d = 32'(hold_q);
            W_ST_TIN:  rd_d = 32'(st_tin);
            W_ST_TOUT: rd_d = 32'(st_tout);
            W_ST_CHI:  rd_d = 32'(st_chi);
            W_ST_CHO:  rd_d = 32'(st_cho);
            W_LKSTAT:  rd_d = {31'd0, locked};
            default:   rd_d = '0;
        endcase
        for (int n = 0; n < N_TIN; n++)
            if (widx == W_INMASK + 10'(n)) rd_d = 32'(inm_q[n]);
        for (int n = 0; n < N_TOUT; n++)
            if (widx == W_OUTMASK + 10'(n)) rd_d = 32'(outm_q[n]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
            if (rd_en) rdata_q <= rd_d;
        end
    end

    generate
        for (genvar n = 0; n < N_TIN; n++) begin : g_inm
            assign in_mask[n*N_CH +: N_CH] = inm_q[n];
        end
        for (genvar n = 0; n < N_TOUT; n++) begin : g_outm
            assign out_mask[n*N_CH +: N_CH] = outm_q[n];
        end
    endgenerate

    assign en       = en_q;
    assign sw_hold  = hold_q;
    assign sw_pulse = pulse_q;
    assign rdata    = rdata_q;
    assign rvalid   = rvalid_q;

    logic unused_bits;
    assign unused_bits = ^{addr[1:0], wdata};

    p_closed_keeps_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(en_q) && $stable(in_mask) && $stable(out_mask) && $stable(hold_q)));
    p_pulse_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulse_q != '0) && !(wr_ok && widx == W_PULSE)) |=> (pulse_q == '0));
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
    parameter int N_TIN  = 8,
    parameter int N_TOUT = 8,
    parameter int N_CH   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [N_TIN-1:0]       trig_in,
    input  logic [N_TIN*N_CH-1:0]  in_mask,
    input  logic [N_TOUT*N_CH-1:0] out_mask,
    input  logic [N_CH-1:0]        sw_hold,
    input  logic [N_CH-1:0]        sw_pulse,
    input  logic [N_TOUT-1:0]      ack,
    output logic [N_CH-1:0]        ch_from_in,
    output logic [N_CH-1:0]        ch_active,
    output logic [N_TOUT-1:0]      trig_out
);
    logic [N_TOUT-1:0] hit, trig_q;

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            logic [N_TIN-1:0] col;
            for (genvar n = 0; n < N_TIN; n++) begin : g_col
                assign col[n] = in_mask[n*N_CH + c];
            end
            assign ch_from_in[c] = |(col & trig_in);
        end
        for (genvar n = 0; n < N_TOUT; n++) begin : g_out
            assign hit[n] = en && |(ch_active & out_mask[n*N_CH +: N_CH]);
        end
    endgenerate

    assign ch_active = ch_from_in | sw_hold | sw_pulse;

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= hit | (trig_q & ~ack);
    end

    assign trig_out = trig_q;

    p_no_rise_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((trig_q & ~$past(trig_q)) == '0));
    p_fall_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig_q) & ~trig_q & ~$past(ack)) == '0));
    p_ack_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((trig_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
    parameter int N_TIN  = 8,
    parameter int N_TOUT = 8,
    parameter int N_CH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [N_TIN-1:0]  trig_in,
    output logic [N_TOUT-1:0] trig_out
);
    logic                   locked, en;
    logic [N_TIN*N_CH-1:0]  in_mask;
    logic [N_TOUT*N_CH-1:0] out_mask;
    logic [N_CH-1:0]        sw_hold, sw_pulse, ch_from_in, ch_active;
    logic [N_TOUT-1:0]      ack;

    xtrig_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .locked(locked)
    );

    xtrig_regs #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .locked(locked), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .st_tin(trig_in), .st_tout(trig_out),
        .st_chi(ch_from_in), .st_cho(ch_active), .en(en), .in_mask(in_mask),
        .out_mask(out_mask), .sw_hold(sw_hold), .sw_pulse(sw_pulse), .ack(ack),
        .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    xtrig_route #(.N_TIN(N_TIN), .N_TOUT(N_TOUT), .N_CH(N_CH)) u_route (
        .clk(clk), .rst_n(rst_n), .en(en), .trig_in(trig_in), .in_mask(in_mask),
        .out_mask(out_mask), .sw_hold(sw_hold), .sw_pulse(sw_pulse), .ack(ack),
        .ch_from_in(ch_from_in), .ch_active(ch_active), .trig_out(trig_out)
    );
endmodule

// File: tb/tb_xtrig_matrix.sv
module tb_xtrig_matrix;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  trig_in = '0;
    logic [7:0]  trig_out;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] exp_q [$];
    logic [11:0] adr_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xtrig_matrix dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .trig_in(trig_in), .trig_out(trig_out)
    );

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0;
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); adr_q.push_back(a); tag_q.push_back(tag);
        bus_rd = 1; bus_addr = a;
        step();
        bus_rd = 0;
    endtask

    task automatic chk_out(input logic [7:0] e, input string tag);
        checks++;
        if (trig_out !== e) begin
            fails++;
            $display("FAIL %s trig_out actual=%h expected=%h", tag, trig_out, e);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                logic [11:0] a;
                string t;
                e = exp_q.pop_front(); a = adr_q.pop_front(); t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s read @%h actual=%h expected=%h", t, a, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_expect(12'hFB4, 32'h1, "R1 lock status");
        rd_expect(12'h000, 32'h0, "R1 ctrl");
        rd_expect(12'h020, 32'h0, "R1 in mask");
        rd_expect(12'h0BC, 32'h0, "R1 out mask");
        chk_out(8'h00, "R1");
        // R3 writes while closed ignored
        wr(12'h000, 32'h1);
        wr(12'h028, 32'hF);
        rd_expect(12'h000, 32'h0, "R3 ctrl closed");
        rd_expect(12'h028, 32'h0, "R3 mask closed");
        // R2 unlock
        wr(12'hFB0, 32'hC5ACCE55);
        rd_expect(12'hFB4, 32'h0, "R2 open");
        // R5 R6 configure
        wr(12'h000, 32'h1);
        wr(12'h028, 32'h2);
        wr(12'h0B4, 32'h2);
        rd_expect(12'h028, 32'h2, "R5 in mask 2");
        rd_expect(12'h0B4, 32'h2, "R6 out mask 5");
        chk_out(8'h00, "R6 idle");
        trig_in = 8'h04;
        step();
        chk_out(8'h20, "R6 routed");
        rd_expect(12'h138, 32'h2, "R5 chan in status");
        rd_expect(12'h130, 32'h04, "R11 trig in status");
        rd_expect(12'h134, 32'h20, "R11 trig out status");
        // R8 ack while active
        wr(12'h010, 32'h20);
        chk_out(8'h20, "R8");
        // R7 hold then ack
        trig_in = 8'h00;
        step(); step();
        chk_out(8'h20, "R7 held");
        wr(12'h010, 32'h20);
        chk_out(8'h00, "R7 acked");
        // R9 software set/clear
        wr(12'h014, 32'h2);
        rd_expect(12'h13C, 32'h2, "R9 set");
        chk_out(8'h20, "R9 via set");
        wr(12'h018, 32'h2);
        rd_expect(12'h13C, 32'h0, "R9 clear");
        wr(12'h010, 32'h20);
        chk_out(8'h00, "R9 ack");
        // R10 pulse
        wr(12'h01C, 32'h2);
        rd_expect(12'h13C, 32'h2, "R10 pulse on");
        rd_expect(12'h13C, 32'h0, "R10 pulse off");
        chk_out(8'h20, "R10 latched");
        wr(12'h010, 32'h20);
        // R4 disabled
        wr(12'h000, 32'h0);
        trig_in = 8'h04;
        step(); step();
        chk_out(8'h00, "R4 disabled");
        rd_expect(12'h138, 32'h2, "R4 channel still active");
        trig_in = 8'h00;
        wr(12'h000, 32'h1);
        // R12 unmapped
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h0C0, 32'hF);
        rd_expect(12'h100, 32'h0, "R12 unmapped 100");
        rd_expect(12'h0C0, 32'h0, "R12 unmapped 0C0");
        rd_expect(12'h000, 32'h1, "R12 ctrl untouched");
        // R2 relock, R3 ignored
        wr(12'hFB0, 32'h0);
        rd_expect(12'hFB4, 32'h1, "R2 relock");
        wr(12'h000, 32'h0);
        rd_expect(12'h000, 32'h1, "R3 ctrl kept");
        step(); step();
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule